// File: doc/BRIEF.md
# Misaligned Operand Read and Cache Entry Fill Sequencer

This block turns one 32-bit data-read request at any byte address into a series of bus read cycles on an external bus whose devices report their width on each cycle. The operand may straddle two 4-byte cache entries. In that case the block fetches both entries completely. It returns the four operand bytes as soon as they are all in hand. It writes each finished entry into the data cache with a single strobe.

Within an entry, fetching begins at the requested byte and wraps around. The second entry is then read from its lowest byte upward. Each cycle's reported width decides how many bytes that cycle delivers, and the next address skips past them. The width may therefore change from one cycle to the next. A cycle can also report that its data must not be cached, or it can end in a bus error. A bus error on operand bytes raises a fault at once. A bus error on bytes that are only wanted for the fill abandons that entry quietly.

Top module: `mlf_fill_seq`

## Requirements
- R1: An 8-bit response (`bus_size`=00) delivers one byte per cycle. For a request at byte 6, the addresses issued are 6, 7, 4, 5, 8, 9, 10, 11, in that order.
- R2: A 16-bit response (`bus_size`=01) delivers the aligned half-entry that holds the address. For a request at byte 6, the addresses issued are 6, 4, 8, 10.
- R3: A 32-bit response (`bus_size`=1x) delivers the whole entry. For a request at byte 6, exactly two cycles are issued: the first at address 6 and the second at address 8.
- R4: `bus_sterm` ends a cycle as a 32-bit transfer whatever `bus_size` holds. It gives the same two-cycle sequence as R3.
- R5: The width is taken afresh on every cycle, and bytes always arrive on lane k (`bus_rdata[8k+7:8k]` carries address base+k). With widths 8, 16, 32, 8, 16, 16 and a request at byte 5, the addresses issued are 5, 6, 4, 8, 9, 10.
- R6: Each completed entry produces a one-cycle `cache_we`, with `cache_addr` set to the entry's aligned address and byte k of `cache_data` set to the byte at that address plus k.
- R7: If `bus_ci` is high on any cycle of an entry, that entry is not written. Other entries are unaffected.
- R8: `op_valid` pulses exactly once, on the cycle after the last operand byte arrives. Byte i of `op_data` is the byte at request address plus i. An aligned request issues cycles for one entry only.
- R9: A `bus_err` on a cycle that carries any operand byte gives a one-cycle `bus_fault`. It ends the operation with no `op_valid` and no write of that entry.
- R10: A `bus_err` on a cycle that carries only fill bytes abandons that entry with no write and no `bus_fault`. The block then moves on to the next entry, if there is one, and `op_valid` is still produced.
- R11: `bus_addr` stays unchanged while a cycle waits for termination. `req_valid` is ignored while `bus_cyc` is high.
- R12: After reset, `bus_cyc`, `cache_we`, `op_valid` and `bus_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request strobe, taken only when idle |
| req_addr | input | AW | Byte address of the 32-bit operand |
| bus_cyc | output | 1 | A bus read cycle is outstanding |
| bus_addr | output | AW | Byte address of the current bus cycle |
| bus_rdata | input | 32 | Read data, byte lane k carries entry byte k |
| bus_size | input | 2 | Width of this response: 00 = 8, 01 = 16, 1x = 32 bits |
| bus_ack | input | 1 | Sized termination of the current cycle |
| bus_sterm | input | 1 | Synchronous 32-bit termination of the current cycle |
| bus_err | input | 1 | Bus error termination, overrides the other terminations |
| bus_ci | input | 1 | Data of this cycle must not be cached |
| cache_we | output | 1 | One-cycle write strobe for a filled entry |
| cache_addr | output | AW | Aligned address of the entry written |
| cache_data | output | 32 | Entry bytes, byte k at bits 8k+7:8k |
| op_valid | output | 1 | One-cycle pulse, operand complete |
| op_data | output | 32 | Operand, byte i from request address plus i |
| bus_fault | output | 1 | One-cycle bus-error exception pulse |

## Verification
The assertions assume that the environment terminates a cycle only while `bus_cyc` is high. They also assume that `bus_ci` and `bus_err` are meaningful only on a terminating cycle, and that the reported width stays constant during any single cycle. The bench drives the terminations, the width and the inhibit flag only on negative edges where it has just seen `bus_cyc` high. It returns every termination input to zero as soon as the sequence ends. Wait states are introduced by holding all terminations low for a whole cycle, so the address-hold property is exercised and not merely assumed.

// File: rtl/mlf_pkg.sv
package mlf_pkg;
    localparam int unsigned ENT_BYTES = 4;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned DATA_W    = ENT_BYTES * LANE_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
endpackage

// File: rtl/mlf_chunk.sv
// Decides which entry slots one response delivers and where the next cycle points.
module mlf_chunk
    import mlf_pkg::*;
(
    input  logic [1:0] port_sz,
    input  logic       sterm,
    input  logic [1:0] slot,
    input  logic [1:0] start,
    input  logic [3:0] got,
    output logic [3:0] take,
    output logic [3:0] got_nx,
    output logic [1:0] slot_nx,
    output logic       full
);
    always_comb begin
        if (sterm || port_sz[1]) begin
            take = 4'b1111;
        end else if (port_sz == SZ_HALF) begin
            take = slot[1] ? 4'b1100 : 4'b0011;
        end else begin
            take = 4'b0001 << slot;
        end
        got_nx = got | take;
        full   = &got_nx;
    end

    // First slot still missing, walking from start with wrap.
    always_comb begin
        slot_nx = start;
        for (int i = ENT_BYTES - 1; i >= 0; i--) begin
            logic [1:0] k;
            k = start + 2'(i);
            if (!got_nx[k]) slot_nx = k;
        end
    end
endmodule

// File: rtl/mlf_assemble.sv
// Steers received lanes into the entry buffer and the operand register.
module mlf_assemble
    import mlf_pkg::*;
(
    input  logic              ent,
    input  logic [1:0]        off,
    input  logic [3:0]        take,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] ebuf,
    input  logic [DATA_W-1:0] opb,
    input  logic [3:0]        opg,
    output logic [DATA_W-1:0] ebuf_nx,
    output logic [DATA_W-1:0] opb_nx,
    output logic [3:0]        opg_nx,
    output logic              op_hit
);
    logic [2:0] idx [ENT_BYTES];
    logic [3:0] hit;

    for (genvar k = 0; k < ENT_BYTES; k++) begin : g_lane
        // Operand index of this lane; bit 2 set means outside the operand.
        assign idx[k] = {ent, 2'(k)} - {1'b0, off};
        assign hit[k] = take[k] & ~idx[k][2];
        assign ebuf_nx[k*LANE_W +: LANE_W] =
            take[k] ? rdata[k*LANE_W +: LANE_W] : ebuf[k*LANE_W +: LANE_W];
    end

    assign op_hit = |hit;

    always_comb begin
        opb_nx = opb;
        opg_nx = opg;
        for (int k = 0; k < ENT_BYTES; k++) begin
            if (hit[k]) begin
                opb_nx[32'(idx[k][1:0]) * LANE_W +: LANE_W] = rdata[k*LANE_W +: LANE_W];
                opg_nx[idx[k][1:0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mlf_fill_seq.sv
module mlf_fill_seq
    import mlf_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic              bus_cyc,
    output logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        bus_size,
    input  logic              bus_ack,
    input  logic              bus_sterm,
    input  logic              bus_err,
    input  logic              bus_ci,
    output logic              cache_we,
    output logic [AW-1:0]     cache_addr,
    output logic [DATA_W-1:0] cache_data,
    output logic              op_valid,
    output logic [DATA_W-1:0] op_data,
    output logic              bus_fault
);
    localparam int unsigned WW = AW - 2;

    typedef struct packed {
        seq_st_e           st;
        logic [WW-1:0]     base;
        logic [1:0]        off;
        logic              ent;
        logic [1:0]        cur;
        logic [3:0]        got;
        logic              ci;
        logic [DATA_W-1:0] ebuf;
        logic [DATA_W-1:0] opb;
        logic [3:0]        opg;
        logic              we;
        logic [WW-1:0]     waddr;
        logic [DATA_W-1:0] wdata;
        logic              opv;
        logic              exc;
    } seq_s;

    localparam seq_s SEQ_RST = '{
        st: ST_IDLE, base: '0, off: '0, ent: 1'b0, cur: '0, got: '0, ci: 1'b0,
        ebuf: '0, opb: '0, opg: '0, we: 1'b0, waddr: '0, wdata: '0,
        opv: 1'b0, exc: 1'b0
    };

    seq_s seq_d, seq_q;

    logic [WW-1:0]     ent_word;
    logic [1:0]        ent_start;
    logic [3:0]        take, got_nx;
    logic [1:0]        slot_nx;
    logic              ent_full;
    logic [DATA_W-1:0] ebuf_nx, opb_nx;
    logic [3:0]        opg_nx;
    logic              op_hit;
    logic              term;

    assign ent_word  = seq_q.base + WW'(seq_q.ent);
    assign ent_start = seq_q.ent ? 2'b00 : seq_q.off;
    assign term      = bus_ack | bus_sterm | bus_err;

    mlf_chunk u_chunk (
        .port_sz (bus_size),
        .sterm   (bus_sterm),
        .slot    (seq_q.cur),
        .start   (ent_start),
        .got     (seq_q.got),
        .take    (take),
        .got_nx  (got_nx),
        .slot_nx (slot_nx),
        .full    (ent_full)
    );

    mlf_assemble u_asm (
        .ent     (seq_q.ent),
        .off     (seq_q.off),
        .take    (take),
        .rdata   (bus_rdata),
        .ebuf    (seq_q.ebuf),
        .opb     (seq_q.opb),
        .opg     (seq_q.opg),
        .ebuf_nx (ebuf_nx),
        .opb_nx  (opb_nx),
        .opg_nx  (opg_nx),
        .op_hit  (op_hit)
    );

    always_comb begin
        logic next_ent;
        seq_d     = seq_q;
        seq_d.we  = 1'b0;
        seq_d.opv = 1'b0;
        seq_d.exc = 1'b0;
        next_ent  = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st   = ST_RUN;
                    seq_d.base = req_addr[AW-1:2];
                    seq_d.off  = req_addr[1:0];
                    seq_d.cur  = req_addr[1:0];
                    seq_d.ent  = 1'b0;
                    seq_d.got  = '0;
                    seq_d.ci   = 1'b0;
                    seq_d.opg  = '0;
                end
            end
            ST_RUN: begin
                if (term) begin
                    if (bus_err) begin
                        if (op_hit) begin
                            seq_d.exc = 1'b1;
                            seq_d.st  = ST_IDLE;
                        end else begin
                            next_ent = 1'b1;
                        end
                    end else begin
                        seq_d.got  = got_nx;
                        seq_d.ebuf = ebuf_nx;
                        seq_d.opb  = opb_nx;
                        seq_d.opg  = opg_nx;
                        seq_d.ci   = seq_q.ci | bus_ci;
                        seq_d.cur  = slot_nx;
                        if ((&opg_nx) && !(&seq_q.opg)) seq_d.opv = 1'b1;
                        if (ent_full) begin
                            next_ent = 1'b1;
                            if (!(seq_q.ci | bus_ci)) begin
                                seq_d.we    = 1'b1;
                                seq_d.waddr = ent_word;
                                seq_d.wdata = ebuf_nx;
                            end
                        end
                    end
                    if (next_ent) begin
                        if (!seq_q.ent && seq_q.off != 2'b00) begin
                            seq_d.ent = 1'b1;
                            seq_d.cur = 2'b00;
                            seq_d.got = '0;
                            seq_d.ci  = 1'b0;
                        end else begin
                            seq_d.st = ST_IDLE;
                        end
                    end
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign bus_cyc    = (seq_q.st == ST_RUN);
    assign bus_addr   = {ent_word, seq_q.cur};
    assign cache_we   = seq_q.we;
    assign cache_addr = {seq_q.waddr, 2'b00};
    assign cache_data = seq_q.wdata;
    assign op_valid   = seq_q.opv;
    assign op_data    = seq_q.opb;
    assign bus_fault  = seq_q.exc;

    // R11: an unterminated cycle keeps its address
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !term) |=> $stable(bus_addr))
        else $error("bus_addr moved during wait");

    // R6: a write strobe only follows a cycle that was on the bus
    p_we_after_cyc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cache_we |-> $past(bus_cyc) && !$past(bus_err))
        else $error("cache write without a completing bus cycle");

    // R7: the cycle completing a written entry was cachable
    p_we_not_inhibited_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cache_we |-> !$past(bus_ci))
        else $error("inhibited cycle produced a cache write");

    // R9: fault only after an error and with the sequence ended
    p_fault_after_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |-> $past(bus_err) && !bus_cyc && !op_valid)
        else $error("bus_fault without a preceding error");

    // R8: operand completion follows a normal termination
    p_opv_after_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(bus_ack || bus_sterm) && !$past(bus_err))
        else $error("op_valid without a good termination");

    // R10: the fault and operand pulses never coincide
    p_opv_no_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({op_valid, bus_fault}) <= 1)
        else $error("op_valid together with bus_fault");
endmodule

// File: tb/mlf_fill_seq_tb_top.sv
`timescale 1ns/1ps
module mlf_fill_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        bus_cyc;
    logic [15:0] bus_addr;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_ack = 1'b0, bus_sterm = 1'b0, bus_err = 1'b0, bus_ci = 1'b0;
    logic        cache_we;
    logic [15:0] cache_addr;
    logic [31:0] cache_data;
    logic        op_valid;
    logic [31:0] op_data;
    logic        bus_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mlf_fill_seq #(.AW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .bus_size(bus_size), .bus_ack(bus_ack), .bus_sterm(bus_sterm),
        .bus_err(bus_err), .bus_ci(bus_ci), .cache_we(cache_we),
        .cache_addr(cache_addr), .cache_data(cache_data), .op_valid(op_valid),
        .op_data(op_data), .bus_fault(bus_fault)
    );

    // Observation records of one operation
    logic [15:0] log_addr [16];
    int          n_addr;
    logic [15:0] we_addr [4];
    logic [31:0] we_data [4];
    int          n_we;
    int          n_opv;
    logic [31:0] got_op;
    int          n_fault;

    function automatic logic [7:0] mb(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd37 + 16'd11;
        return t[7:0];
    endfunction

    function automatic logic [31:0] mw(input logic [15:0] a);
        return {mb(a + 16'd3), mb(a + 16'd2), mb(a + 16'd1), mb(a)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // sz: two bits per bus cycle; err_n/ci_n: cycle index or -1
    task automatic run_op(input logic [15:0] a, input logic [15:0] sz, input int err_n,
                          input int ci_n, input bit st, input bit waits, input bit busyreq);
        int          cyc;
        bit          held;
        logic [15:0] hold_addr;
        logic [15:0] base;
        n_addr = 0; n_we = 0; n_opv = 0; n_fault = 0; got_op = '0;
        cyc = 0; held = 0; hold_addr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 40; t++) begin
            if (cache_we) begin
                if (n_we < 4) begin
                    we_addr[n_we] = cache_addr; we_data[n_we] = cache_data;
                end
                n_we++;
            end
            if (op_valid) begin n_opv++; got_op = op_data; end
            if (bus_fault) n_fault++;
            bus_ack = 0; bus_sterm = 0; bus_err = 0; bus_ci = 0;
            req_valid = 1'b0;
            if (bus_cyc) begin
                if (busyreq) begin req_valid = 1'b1; req_addr = 16'h0100; end
                if (held) chk("R11 address held in wait", 32'(bus_addr), 32'(hold_addr));
                if (waits && !held) begin
                    held = 1; hold_addr = bus_addr;
                end else begin
                    held = 0;
                    if (n_addr < 16) log_addr[n_addr] = bus_addr;
                    n_addr++;
                    base = bus_addr & 16'hFFFC;
                    bus_rdata = mw(base);
                    bus_size  = sz[2*(cyc%8) +: 2];
                    bus_sterm = st;
                    bus_ack   = !st;
                    bus_err   = (cyc == err_n);
                    bus_ci    = (cyc == ci_n);
                    cyc++;
                end
            end
            @(negedge clk);
        end
        bus_ack = 0; bus_sterm = 0; bus_err = 0; bus_ci = 0; req_valid = 0;
    endtask

    task automatic expect_seq(input string req, input int n, input logic [127:0] al);
        chk({req, " cycle count"}, 32'(n_addr), 32'(n));
        for (int i = 0; i < n && i < n_addr; i++)
            chk({req, " address order"}, 32'(log_addr[i]), 32'(al[16*i +: 16]));
    endtask

    task automatic expect_out(input string req, input int nw, input logic [15:0] w0,
                              input logic [15:0] w1, input int nop, input logic [15:0] opa,
                              input int nf);
        chk({req, " writes"}, 32'(n_we), 32'(nw));
        if (nw > 0 && n_we > 0) begin
            chk({req, " R6 write address"}, 32'(we_addr[0]), 32'(w0));
            chk({req, " R6 write data"}, we_data[0], mw(w0));
        end
        if (nw > 1 && n_we > 1) begin
            chk({req, " R6 write address"}, 32'(we_addr[1]), 32'(w1));
            chk({req, " R6 write data"}, we_data[1], mw(w1));
        end
        chk({req, " R8 op_valid count"}, 32'(n_opv), 32'(nop));
        if (nop > 0) chk({req, " R8 operand"}, got_op, mw(opa));
        chk({req, " fault count"}, 32'(n_fault), 32'(nf));
    endtask

    function automatic logic [127:0] L(input logic [15:0] a0, a1, a2, a3,
                                       input logic [15:0] a4, a5, a6, a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic t_reset();
        chk("R12 bus_cyc", 32'(bus_cyc), 0);
        chk("R12 cache_we", 32'(cache_we), 0);
        chk("R12 op_valid", 32'(op_valid), 0);
        chk("R12 bus_fault", 32'(bus_fault), 0);
    endtask

    task automatic t_byte_port();
        run_op(16'h0006, 16'h0000, -1, -1, 0, 0, 0);
        expect_seq("R1", 8, L(6, 7, 4, 5, 8, 9, 10, 11));
        expect_out("R1", 2, 16'h0004, 16'h0008, 1, 16'h0006, 0);
    endtask

    task automatic t_half_port();
        run_op(16'h0006, 16'h5555, -1, -1, 0, 0, 0);
        expect_seq("R2", 4, L(6, 4, 8, 10, 0, 0, 0, 0));
        expect_out("R2", 2, 16'h0004, 16'h0008, 1, 16'h0006, 0);
    endtask

    task automatic t_word_port();
        run_op(16'h0006, 16'hAAAA, -1, -1, 0, 0, 0);
        expect_seq("R3", 2, L(6, 8, 0, 0, 0, 0, 0, 0));
        expect_out("R3", 2, 16'h0004, 16'h0008, 1, 16'h0006, 0);
    endtask

    task automatic t_sterm();
        run_op(16'h0006, 16'h0000, -1, -1, 1, 0, 0);
        expect_seq("R4", 2, L(6, 8, 0, 0, 0, 0, 0, 0));
        expect_out("R4", 2, 16'h0004, 16'h0008, 1, 16'h0006, 0);
    endtask

    task automatic t_aligned();
        run_op(16'h0008, 16'h5555, -1, -1, 0, 0, 0);
        expect_seq("R8 aligned", 2, L(8, 10, 0, 0, 0, 0, 0, 0));
        expect_out("R8 aligned", 1, 16'h0008, 16'h0000, 1, 16'h0008, 0);
    endtask

    task automatic t_mixed();
        // widths per cycle: 8,16,32,8,16,16
        run_op(16'h0005, {4'b0, 2'b01, 2'b01, 2'b00, 2'b10, 2'b01, 2'b00}, -1, -1, 0, 0, 0);
        expect_seq("R5", 6, L(5, 6, 4, 8, 9, 10, 0, 0));
        expect_out("R5", 2, 16'h0004, 16'h0008, 1, 16'h0005, 0);
    endtask

    task automatic t_inhibit();
        run_op(16'h0006, 16'h0000, -1, 5, 0, 0, 0);
        expect_seq("R7", 8, L(6, 7, 4, 5, 8, 9, 10, 11));
        expect_out("R7", 1, 16'h0004, 16'h0000, 1, 16'h0006, 0);
    endtask

    task automatic t_fill_err_first();
        run_op(16'h0006, 16'h0000, 2, -1, 0, 0, 0);
        expect_seq("R10 first entry", 7, L(6, 7, 4, 8, 9, 10, 11, 0));
        expect_out("R10 first entry", 1, 16'h0008, 16'h0000, 1, 16'h0006, 0);
    endtask

    task automatic t_fill_err_second();
        run_op(16'h0006, 16'h0000, 6, -1, 0, 0, 0);
        expect_seq("R10 second entry", 7, L(6, 7, 4, 5, 8, 9, 10, 0));
        expect_out("R10 second entry", 1, 16'h0004, 16'h0000, 1, 16'h0006, 0);
    endtask

    task automatic t_operand_err();
        run_op(16'h0006, 16'h0000, 1, -1, 0, 0, 0);
        expect_seq("R9", 2, L(6, 7, 0, 0, 0, 0, 0, 0));
        expect_out("R9", 0, 16'h0000, 16'h0000, 0, 16'h0000, 1);
    endtask

    task automatic t_wait_busy();
        run_op(16'h0002, 16'h5555, -1, -1, 0, 1, 1);
        expect_seq("R11", 4, L(2, 0, 4, 6, 0, 0, 0, 0));
        expect_out("R11", 2, 16'h0000, 16'h0004, 1, 16'h0002, 0);
        chk("R11 idle after busy request", 32'(bus_cyc), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_byte_port();
        t_half_port();
        t_word_port();
        t_sterm();
        t_aligned();
        t_mixed();
        t_inhibit();
        t_fill_err_first();
        t_fill_err_second();
        t_operand_err();
        t_wait_busy();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule